// File: doc/BRIEF.md
# Acknowledge-Gated Tick Interrupt Injector

This block sits between a periodic tick source and an interrupt request line. Every tick adds one unit to a backlog of undelivered interrupts. One interrupt is released at a time, and only on an injection-opportunity strobe. A release also needs a nonzero backlog and an acknowledge of the interrupt released before it. Slow servicing therefore delays ticks but does not merge them into one interrupt. Each acknowledge removes one unit from the backlog, so the ticks drain one by one.

Each release drives the output as a single-cycle high level followed at once by a low level. A downstream edge-sensitive controller sees exactly one rising edge per release. A reload input clears the backlog when the tick source is reprogrammed. The backlog width is a parameter, and the counter holds at its maximum when full rather than wrapping to zero.

Top module: `tick_irq_injector`

## Requirements
- R1: Each cycle with `tick` high, and with `ack` and `reload` low, raises the backlog count by one at the next clock edge.
- R2: A release happens in a cycle only when `inject_ok` is high, the backlog is nonzero, the acknowledged flag is set, `irq` is low and `reload` is low. A release clears the acknowledged flag unless `ack` or `reload` is high in the same cycle.
- R3: Each cycle with `ack` high, and with `tick` and `reload` low, lowers the backlog by one at the next edge. A backlog of zero stays at zero. Any `ack` sets the acknowledged flag.
- R4: `reload` clears the backlog to zero and sets the acknowledged flag at the next edge. It overrides `tick` and `ack` and blocks a release in the same cycle.
- R5: `irq` is registered. It is high for exactly the one cycle after a release and is never high in two consecutive cycles.
- R6: The backlog saturates at 2^PEND_W-1. A tick at the maximum leaves it unchanged.
- R7: When `tick` and `ack` are both high without `reload`, the backlog is unchanged and the acknowledged flag is set.
- R8: `pending_nz` is a combinational output that is high exactly when the registered backlog is nonzero.
- R9: While `rst_n` is low, the backlog is zero, the acknowledged flag is set and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload | input | 1 | Tick source reprogrammed: clear the backlog and re-arm |
| tick | input | 1 | One period of the tick source elapsed |
| ack | input | 1 | Previous interrupt acknowledged |
| inject_ok | input | 1 | Injection opportunity strobe |
| irq | output | 1 | Interrupt pulse, one cycle high per release |
| pending_nz | output | 1 | Backlog is nonzero |

## Verification
The backlog count is hidden, so a wrong count appears at the ports in two ways. `pending_nz` falls after too few or too many acknowledges. A missing or extra `irq` pulse appears on a later strobe. Errors near the saturation limit or at zero can take several cycles to surface. The bench therefore runs a small width, where the limit is reached in a few ticks. It compares both outputs against an arithmetic model on every cycle of a long pseudo-random sequence. A wrong acknowledged flag shows up on the first strobe after the flag should have changed: either a release that should have been blocked, or a release that never comes.

// File: rtl/tick_irq_injector_pkg.sv
package tick_irq_injector_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_e;

  // Reload wins; a tick and an acknowledge together cancel out.
  function automatic cnt_op_e pick_op(input logic reload, input logic tick,
                                      input logic ack);
    if (reload)            pick_op = CNT_CLR;
    else if (tick && !ack) pick_op = CNT_INC;
    else if (ack && !tick) pick_op = CNT_DEC;
    else                   pick_op = CNT_HOLD;
  endfunction

endpackage

// File: rtl/tick_irq_backlog.sv
module tick_irq_backlog
  import tick_irq_injector_pkg::*;
#(
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cnt_op_e           op,
  output logic [PEND_W-1:0] count,
  output logic              nonzero,
  output logic              at_max
);
  localparam logic [PEND_W-1:0] CNT_MAX = {PEND_W{1'b1}};
  localparam logic [PEND_W-1:0] CNT_ONE = {{(PEND_W-1){1'b0}}, 1'b1};
  localparam logic [PEND_W-1:0] CNT_ZERO = {PEND_W{1'b0}};

  function automatic logic [PEND_W-1:0] step(input cnt_op_e o,
                                             input logic [PEND_W-1:0] c);
    case (o)
      CNT_INC: step = (c == CNT_MAX) ? c : c + CNT_ONE;
      CNT_DEC: step = (c == CNT_ZERO) ? c : c - CNT_ONE;
      CNT_CLR: step = CNT_ZERO;
      default: step = c;
    endcase
  endfunction

  logic [PEND_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= CNT_ZERO;
    else        cnt_q <= step(op, cnt_q);
  end

  assign count   = cnt_q;
  assign nonzero = (cnt_q != CNT_ZERO);
  assign at_max  = (cnt_q == CNT_MAX);
endmodule

// File: rtl/tick_irq_gate.sv
module tick_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic ack,
  input  logic strobe,
  input  logic have_work,
  input  logic busy,
  output logic issue,
  output logic acked
);
  logic acked_q;

  assign issue = strobe && have_work && acked_q && !busy && !reload;

  always_ff @(posedge clk) begin
    if (!rst_n)             acked_q <= 1'b1;
    else if (reload || ack) acked_q <= 1'b1;
    else if (issue)         acked_q <= 1'b0;
  end

  assign acked = acked_q;
endmodule

// File: rtl/tick_irq_pulse.sv
module tick_irq_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire;
  end

  assign irq = irq_q;
endmodule

// File: rtl/tick_irq_injector.sv
module tick_irq_injector
  import tick_irq_injector_pkg::*;
#(
  parameter int PEND_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic tick,
  input  logic ack,
  input  logic inject_ok,
  output logic irq,
  output logic pending_nz
);
  cnt_op_e           cnt_op;
  logic [PEND_W-1:0] pend_cnt;
  logic              pend_nz_w;
  logic              pend_at_max;
  logic              issue_w;
  logic              acked_w;
  logic              irq_w;

  assign cnt_op = pick_op(reload, tick, ack);

  tick_irq_backlog #(.PEND_W(PEND_W)) u_backlog (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (cnt_op),
    .count   (pend_cnt),
    .nonzero (pend_nz_w),
    .at_max  (pend_at_max)
  );

  tick_irq_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload    (reload),
    .ack       (ack),
    .strobe    (inject_ok),
    .have_work (pend_nz_w),
    .busy      (irq_w),
    .issue     (issue_w),
    .acked     (acked_w)
  );

  tick_irq_pulse u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (issue_w),
    .irq   (irq_w)
  );

  assign irq        = irq_w;
  assign pending_nz = pend_nz_w;
endmodule

// File: rtl/tick_irq_injector_chk.sv
module tick_irq_injector_chk #(
  parameter int PEND_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reload,
  input logic              tick,
  input logic              ack,
  input logic              irq,
  input logic              issue,
  input logic              acked,
  input logic [PEND_W-1:0] pend_cnt,
  input logic              pend_at_max
);
  p_tick_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ack && !reload && !pend_at_max) |=> (pend_cnt == $past(pend_cnt) + 1'b1));

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (acked && pend_cnt != '0));

  p_issue_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !ack && !reload) |=> !acked);

  p_ack_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> acked);

  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '0 && ack && !tick && !reload) |=> (pend_cnt == '0));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (pend_cnt == '0 && acked && !irq));

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(issue));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_at_max && tick && !ack && !reload) |=> pend_at_max);

  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ack && !reload) |=> ($stable(pend_cnt) && acked));
endmodule

bind tick_irq_injector tick_irq_injector_chk #(.PEND_W(PEND_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reload      (reload),
  .tick        (tick),
  .ack         (ack),
  .irq         (irq),
  .issue       (issue_w),
  .acked       (acked_w),
  .pend_cnt    (pend_cnt),
  .pend_at_max (pend_at_max)
);

// File: tb/tick_irq_injector_bench.sv
module tick_irq_injector_bench;
  localparam int PW   = 2;
  localparam int PMAX = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reload = 1'b0, tick = 1'b0, ack = 1'b0, inject_ok = 1'b0;
  logic irq, pending_nz;

  int checks = 0;
  int errors = 0;
  int m_pend = 0;
  bit m_ack = 1'b1;
  bit m_irq = 1'b0;

  always #2.5 clk = ~clk;

  tick_irq_injector #(.PEND_W(PW)) u_tick_irq_injector (
    .clk(clk), .rst_n(rst_n), .reload(reload), .tick(tick), .ack(ack),
    .inject_ok(inject_ok), .irq(irq), .pending_nz(pending_nz)
  );

  task automatic check(input string req, input string what, input logic act,
                       input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, compare.
  task automatic cyc(input bit t, input bit a, input bit s, input bit c,
                     input string req);
    bit iss;
    tick = t; ack = a; inject_ok = s; reload = c;
    @(posedge clk);
    iss = s && (m_pend > 0) && m_ack && !m_irq && !c;
    if (c)               m_pend = 0;
    else if (t && !a)    m_pend = (m_pend == PMAX) ? PMAX : m_pend + 1;
    else if (a && !t)    m_pend = (m_pend == 0) ? 0 : m_pend - 1;
    if (c || a)          m_ack = 1'b1;
    else if (iss)        m_ack = 1'b0;
    m_irq = iss;
    @(negedge clk);
    check(req, "irq", irq, m_irq);
    check(req, "pending_nz", pending_nz, m_pend != 0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    repeat (3) @(negedge clk);
    check("R9", "irq in reset", irq, 1'b0);
    check("R9", "pending_nz in reset", pending_nz, 1'b0);
    rst_n = 1'b1;
    // R9: flag set after reset -> one tick then strobe releases.
    cyc(1, 0, 0, 0, "R1");
    cyc(0, 0, 1, 0, "R9");
    cyc(0, 0, 1, 0, "R2");          // no ack yet -> blocked
    cyc(0, 0, 1, 0, "R2");
    cyc(0, 1, 0, 0, "R3");          // backlog 0
    cyc(0, 1, 0, 0, "R3");          // floor
    cyc(1, 0, 0, 0, "R3");          // backlog 1 (not wrapped)
    cyc(0, 1, 0, 0, "R3");          // back to 0
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, "R6");
    cyc(0, 1, 0, 0, "R6");
    cyc(0, 1, 0, 0, "R6");
    cyc(0, 1, 0, 0, "R6");          // saturated 3 -> 0
    cyc(1, 0, 0, 0, "R7");
    cyc(1, 1, 0, 0, "R7");          // stays 1
    cyc(0, 1, 0, 0, "R7");          // now 0
    cyc(1, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, "R4");
    cyc(1, 1, 1, 1, "R4");          // reload wins, no release
    cyc(0, 0, 1, 0, "R4");          // empty -> nothing
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R5");
    for (int i = 0; i < 8; i++) cyc(0, 1, 1, 0, "R5");
    cyc(0, 0, 0, 1, "R8");
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], lfsr[1] & lfsr[5], lfsr[2] | lfsr[6],
          (lfsr[7:3] == 5'd0), "R8");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule